// File: doc/BRIEF.md
# Single-Pair PHY Control Registers

This block holds the management-side control settings of a single-pair Ethernet PHY. It has two 16-bit words, a basic control word and an extended control word. A host reads and writes them over a simple register port with an address, write data, a write strobe, a read strobe and read data. Reads are combinational and complete in the cycle the read strobe is high. A write is accepted on the rising clock edge.

Every write is checked one field at a time before anything is stored. Capability bits that are hard-wired cannot be changed. A field value that is illegal, or that conflicts with a setting already held, is thrown away and the old value stays. Each such rejection produces a one-cycle control-error pulse that an interrupt block can latch.

Command bits clear themselves. Writing one of them produces a one-cycle pulse and the bit always reads back as 0. The stored settings drive the PHY mode outputs directly: power-down, isolate, loopback kind, power-mode command and test mode.

Top module: `sp_phy_ctrl`

## Requirements
- R1: After reset, a read of the basic word (address 0) returns 0x2100 and a read of the extended word (address 1) returns 0x0000. All pulse outputs and all mode outputs are low.
- R2: In the basic word, bit 13 always reads 1 and bit 8 always reads 1. Bits 12, 9, 7, 6 and 4:0 always read 0. Writes cannot change any of these bits, so the speed code {bit 6, bit 13} stays 01.
- R3: Basic bit 11 is power-down and bit 10 is isolate. A request to set one of them is rejected when the other is already 1, or when the same write also requests the other. A rejected bit keeps its old value. One rejection raises `ctlErrPulse` for exactly the cycle after the write. Power-down and isolate are never both 1.
- R4: A write that clears power-down while power-down is 1 and the stored power mode is 0011 pulses `normalReqPulse` in the cycle after the write.
- R5: Extended bits 15:12 are the power mode. The codes 0011, 1011 and 1100 are stored. The code 0000 leaves the stored value unchanged. Any other code, including 1001 and 1010, is rejected and raises `ctlErrPulse`. `pwrModeCmd` shows the stored code.
- R6: Writing 1 to extended bit 11, bit 10 or bit 9 pulses, for one cycle after the write, `trainRestartPulse`, `cableTestPulse` or `forceSleepPulse` respectively. These bits always read 0.
- R7: Writing 1 to basic bit 15 pulses `swResetPulse` for one cycle and returns every stored field to its reset value in that same cycle. The rest of the data in that write is ignored and raises no control error. Bit 15 always reads 0.
- R8: Basic bit 14 enables loopback and extended bits 8:7 select its kind: 00 internal, 01 or 10 external, 11 remote. At most one of `lbInternal`, `lbExternal` and `lbRemote` is high, and none of them is high while bit 14 is 0.
- R9: Extended bits 6:4 (the test mode) and basic bit 5 (unidirectional enable) are stored and read back as written. Extended bits 3:0 read 0. A write to any other address changes nothing, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Read data; 0 when rdEn is low |
| swResetPulse | output | 1 | Software reset command pulse |
| powerDown | output | 1 | Power-down setting |
| isolate | output | 1 | Isolate setting |
| unidirEnable | output | 1 | Unidirectional transmit enable |
| lbInternal | output | 1 | Internal loopback active |
| lbExternal | output | 1 | External loopback active |
| lbRemote | output | 1 | Remote loopback active |
| pwrModeCmd | output | 4 | Stored power-mode command |
| normalReqPulse | output | 1 | Request to go to Normal mode |
| testMode | output | 3 | Test mode selection |
| trainRestartPulse | output | 1 | Training restart command pulse |
| cableTestPulse | output | 1 | Cable test start pulse |
| forceSleepPulse | output | 1 | Forced sleep command pulse |
| ctlErrPulse | output | 1 | One-cycle control-error event |

## Verification
Two functions can act on the same write. The first pair is the software reset and the power-down/isolate check: one basic write sets bit 15 together with both bit 11 and bit 10. It is judged correct when the reset pulse appears, no control error is raised and every field is back at its reset value. The second pair is a read and a write to the same word in one cycle: the read must return the value held before the write. A behavioural reference model in the bench is compared with every output on every clock. This covers directed cases and a long run of random writes that rarely carry the reset bit.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
  localparam int WORD_W = 16;

  // basic word bit positions (standard management layout)
  localparam int B_RST   = 15;
  localparam int B_LOOP  = 14;
  localparam int B_SPDL  = 13;
  localparam int B_PD    = 11;
  localparam int B_ISO   = 10;
  localparam int B_DUP   = 8;
  localparam int B_SPDM  = 6;
  localparam int B_UNI   = 5;

  // extended word layout
  localparam int X_PM_HI = 15;
  localparam int X_PM_LO = 12;
  localparam int X_TRN   = 11;
  localparam int X_CAB   = 10;
  localparam int X_SLP   = 9;
  localparam int X_LB_HI = 8;
  localparam int X_LB_LO = 7;
  localparam int X_TM_HI = 6;
  localparam int X_TM_LO = 4;

  localparam logic [3:0] PM_KEEP   = 4'b0000;
  localparam logic [3:0] PM_NORMAL = 4'b0011;
  localparam logic [3:0] PM_SLPREQ = 4'b1011;
  localparam logic [3:0] PM_STBY   = 4'b1100;

  localparam int NPULSE = 6;
  localparam int P_RST = 0, P_TRN = 1, P_CAB = 2, P_SLP = 3, P_ERR = 4, P_NRM = 5;

  typedef struct packed {
    logic       ldBasic;
    logic       ldExt;
    logic       swReset;
    logic       trainGo;
    logic       cableGo;
    logic       sleepGo;
    logic       ctlErr;
    logic       normalReq;
    logic       pdNew;
    logic       isoNew;
    logic       loopNew;
    logic       uniNew;
    logic [3:0] pmNew;
    logic [1:0] lbTypeNew;
    logic [2:0] testNew;
  } ctlStrobe_t;
endpackage

// File: rtl/phyctl_decode.sv
module phyctl_decode
  import phyctl_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int BASIC_ADDR = 0,
  parameter int EXT_ADDR   = 1
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              curPd,
  input  logic              curIso,
  input  logic [3:0]        curPm,
  output ctlStrobe_t        st
);
  localparam logic [ADDR_W-1:0] A_BASIC = ADDR_W'(BASIC_ADDR);
  localparam logic [ADDR_W-1:0] A_EXT   = ADDR_W'(EXT_ADDR);

  logic wrBasic, wrExt, pdReq, isoReq, pdRej, isoRej, pmLegal;
  logic [3:0] pmWr;
  logic unusedBits;

  assign unusedBits = ^{wrData[B_SPDL], wrData[12], wrData[9], wrData[B_DUP],
                        wrData[7], wrData[B_SPDM], wrData[4:0], wrData[3:0]};

  assign wrBasic = wrEn && (regAddr == A_BASIC);
  assign wrExt   = wrEn && (regAddr == A_EXT);
  assign pdReq   = wrData[B_PD];
  assign isoReq  = wrData[B_ISO];
  assign pdRej   = pdReq && !curPd && (curIso || isoReq);
  assign isoRej  = isoReq && !curIso && (curPd || pdReq);
  assign pmWr    = wrData[X_PM_HI:X_PM_LO];
  assign pmLegal = (pmWr == PM_NORMAL) || (pmWr == PM_SLPREQ) || (pmWr == PM_STBY);

  always_comb begin
    st           = '0;
    st.swReset   = wrBasic && wrData[B_RST];
    st.ldBasic   = wrBasic && !wrData[B_RST];
    st.ldExt     = wrExt;
    st.pdNew     = pdReq && !pdRej;
    st.isoNew    = isoReq && !isoRej;
    st.loopNew   = wrData[B_LOOP];
    st.uniNew    = wrData[B_UNI];
    st.pmNew     = pmLegal ? pmWr : curPm;
    st.lbTypeNew = wrData[X_LB_HI:X_LB_LO];
    st.testNew   = wrData[X_TM_HI:X_TM_LO];
    st.trainGo   = wrExt && wrData[X_TRN];
    st.cableGo   = wrExt && wrData[X_CAB];
    st.sleepGo   = wrExt && wrData[X_SLP];
    st.ctlErr    = (st.ldBasic && (pdRej || isoRej)) ||
                   (wrExt && !pmLegal && (pmWr != PM_KEEP));
    st.normalReq = st.ldBasic && curPd && !pdReq && (curPm == PM_NORMAL);
  end
endmodule

// File: rtl/phyctl_regs.sv
module phyctl_regs
  import phyctl_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int BASIC_ADDR = 0,
  parameter int EXT_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              pdQ,
  output logic              isoQ,
  output logic              uniQ,
  output logic [3:0]        pmQ,
  output logic [2:0]        testQ,
  output logic              lbInternal,
  output logic              lbExternal,
  output logic              lbRemote,
  output logic [NPULSE-1:0] pulseQ
);
  localparam logic [ADDR_W-1:0] A_BASIC = ADDR_W'(BASIC_ADDR);
  localparam logic [ADDR_W-1:0] A_EXT   = ADDR_W'(EXT_ADDR);

  logic       loopQ;
  logic [1:0] lbTypeQ;
  logic [NPULSE-1:0] pulseReq;
  logic [WORD_W-1:0] basicWord, extWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdQ <= 1'b0; isoQ <= 1'b0; loopQ <= 1'b0; uniQ <= 1'b0;
      pmQ <= PM_KEEP; lbTypeQ <= 2'b00; testQ <= 3'b000;
    end else if (st.swReset) begin
      pdQ <= 1'b0; isoQ <= 1'b0; loopQ <= 1'b0; uniQ <= 1'b0;
      pmQ <= PM_KEEP; lbTypeQ <= 2'b00; testQ <= 3'b000;
    end else if (st.ldBasic) begin
      pdQ <= st.pdNew; isoQ <= st.isoNew; loopQ <= st.loopNew; uniQ <= st.uniNew;
    end else if (st.ldExt) begin
      pmQ <= st.pmNew; lbTypeQ <= st.lbTypeNew; testQ <= st.testNew;
    end
  end

  assign pulseReq[P_RST] = st.swReset;
  assign pulseReq[P_TRN] = st.trainGo;
  assign pulseReq[P_CAB] = st.cableGo;
  assign pulseReq[P_SLP] = st.sleepGo;
  assign pulseReq[P_ERR] = st.ctlErr;
  assign pulseReq[P_NRM] = st.normalReq;

  for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseQ[i] <= 1'b0;
      else       pulseQ[i] <= pulseReq[i];
    end
  end

  assign lbInternal = loopQ && (lbTypeQ == 2'b00);
  assign lbExternal = loopQ && (lbTypeQ == 2'b01 || lbTypeQ == 2'b10);
  assign lbRemote   = loopQ && (lbTypeQ == 2'b11);

  always_comb begin
    basicWord          = '0;
    basicWord[B_LOOP]  = loopQ;
    basicWord[B_SPDL]  = 1'b1;
    basicWord[B_PD]    = pdQ;
    basicWord[B_ISO]   = isoQ;
    basicWord[B_DUP]   = 1'b1;
    basicWord[B_UNI]   = uniQ;
    extWord                    = '0;
    extWord[X_PM_HI:X_PM_LO]   = pmQ;
    extWord[X_LB_HI:X_LB_LO]   = lbTypeQ;
    extWord[X_TM_HI:X_TM_LO]   = testQ;
    if (!rdEn)                    rdData = '0;
    else if (regAddr == A_BASIC)  rdData = basicWord;
    else if (regAddr == A_EXT)    rdData = extWord;
    else                          rdData = '0;
  end

  // R3: power-down and isolate never coexist
  p_pd_iso_excl_r3: assert property (@(posedge clk) disable iff (!rstN) !(pdQ && isoQ));
  // R3: an error event only follows a write
  p_err_after_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ[P_ERR] |-> $past(st.ldBasic || st.ldExt));
  // R5: stored power mode stays in the accepted set
  p_pm_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pmQ == PM_KEEP) || (pmQ == PM_NORMAL) || (pmQ == PM_SLPREQ) || (pmQ == PM_STBY));
  // R7: reset pulse coincides with default state
  p_reset_defaults_r7: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ[P_RST] |-> (!pdQ && !isoQ && !loopQ && !uniQ && pmQ == PM_KEEP && testQ == 3'b000));
  // R8: at most one loopback kind
  p_lb_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lbInternal, lbExternal, lbRemote}));
endmodule

// File: rtl/sp_phy_ctrl.sv
module sp_phy_ctrl
  import phyctl_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int BASIC_ADDR = 0,
  parameter int EXT_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [15:0]       rdData,
  output logic              swResetPulse,
  output logic              powerDown,
  output logic              isolate,
  output logic              unidirEnable,
  output logic              lbInternal,
  output logic              lbExternal,
  output logic              lbRemote,
  output logic [3:0]        pwrModeCmd,
  output logic              normalReqPulse,
  output logic [2:0]        testMode,
  output logic              trainRestartPulse,
  output logic              cableTestPulse,
  output logic              forceSleepPulse,
  output logic              ctlErrPulse
);
  ctlStrobe_t st;
  logic [NPULSE-1:0] pulseQ;

  phyctl_decode #(.ADDR_W(ADDR_W), .BASIC_ADDR(BASIC_ADDR), .EXT_ADDR(EXT_ADDR)) u_decode (
    .regAddr(regAddr), .wrData(wrData), .wrEn(wrEn),
    .curPd(powerDown), .curIso(isolate), .curPm(pwrModeCmd), .st(st)
  );

  phyctl_regs #(.ADDR_W(ADDR_W), .BASIC_ADDR(BASIC_ADDR), .EXT_ADDR(EXT_ADDR)) u_regs (
    .clk(clk), .rstN(rstN), .st(st), .rdEn(rdEn), .regAddr(regAddr), .rdData(rdData),
    .pdQ(powerDown), .isoQ(isolate), .uniQ(unidirEnable), .pmQ(pwrModeCmd), .testQ(testMode),
    .lbInternal(lbInternal), .lbExternal(lbExternal), .lbRemote(lbRemote), .pulseQ(pulseQ)
  );

  assign swResetPulse      = pulseQ[P_RST];
  assign trainRestartPulse = pulseQ[P_TRN];
  assign cableTestPulse    = pulseQ[P_CAB];
  assign forceSleepPulse   = pulseQ[P_SLP];
  assign ctlErrPulse       = pulseQ[P_ERR];
  assign normalReqPulse    = pulseQ[P_NRM];
endmodule

// File: tb/sp_phy_ctrl_test.sv
`timescale 1ns/1ps
module sp_phy_ctrl_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] rdData;
  logic swResetPulse, powerDown, isolate, unidirEnable, lbInternal, lbExternal, lbRemote;
  logic [3:0] pwrModeCmd;
  logic normalReqPulse, trainRestartPulse, cableTestPulse, forceSleepPulse, ctlErrPulse;
  logic [2:0] testMode;

  int tests = 0, fails = 0;
  bit done = 0, checking = 0;

  always #2 clk = ~clk;

  sp_phy_ctrl uut (.*);

  // behavioural reference model
  bit mPd, mIso, mLoop, mUni;
  bit [3:0] mPm;
  bit [1:0] mLbt;
  bit [2:0] mTest;
  bit eRst, eTrn, eCab, eSlp, eErr, eNrm;
  bit wantPd, wantIso, newPd, newIso;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPd = 0; mIso = 0; mLoop = 0; mUni = 0; mPm = 0; mLbt = 0; mTest = 0;
      {eRst, eTrn, eCab, eSlp, eErr, eNrm} = '0;
    end else begin
      {eRst, eTrn, eCab, eSlp, eErr, eNrm} = '0;
      if (wrEn && regAddr == 0) begin
        if (wrData[15]) begin
          eRst = 1;
          mPd = 0; mIso = 0; mLoop = 0; mUni = 0; mPm = 0; mLbt = 0; mTest = 0;
        end else begin
          wantPd = wrData[11]; wantIso = wrData[10];
          newPd = wantPd; newIso = wantIso;
          if (wantIso && !mIso && (mPd || wantPd)) begin newIso = 0; eErr = 1; end
          if (wantPd && !mPd && (mIso || wantIso)) begin newPd = 0; eErr = 1; end
          if (mPd && !wantPd && mPm == 4'd3) eNrm = 1;
          mPd = newPd; mIso = newIso; mLoop = wrData[14]; mUni = wrData[5];
        end
      end else if (wrEn && regAddr == 1) begin
        case (wrData[15:12])
          4'd0: ;
          4'd3, 4'd11, 4'd12: mPm = wrData[15:12];
          default: eErr = 1;
        endcase
        mLbt = wrData[8:7]; mTest = wrData[6:4];
        eTrn = wrData[11]; eCab = wrData[10]; eSlp = wrData[9];
      end
    end
  end

  function automatic logic [15:0] modelRead(input logic [4:0] a);
    if (a == 0) return {1'b0, mLoop, 1'b1, 1'b0, mPd, mIso, 1'b0, 1'b1, 1'b0, 1'b0, mUni, 5'b0};
    if (a == 1) return {mPm, 3'b000, mLbt, mTest, 4'b0};
    return 16'h0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs every clock
  always @(negedge clk) if (checking) begin
    chk("R7 swResetPulse", 16'(swResetPulse), 16'(eRst));
    chk("R3 ctlErrPulse", 16'(ctlErrPulse), 16'(eErr));
    chk("R4 normalReqPulse", 16'(normalReqPulse), 16'(eNrm));
    chk("R6 trainRestartPulse", 16'(trainRestartPulse), 16'(eTrn));
    chk("R6 cableTestPulse", 16'(cableTestPulse), 16'(eCab));
    chk("R6 forceSleepPulse", 16'(forceSleepPulse), 16'(eSlp));
    chk("R3 powerDown/isolate", 16'({powerDown, isolate}), 16'({mPd, mIso}));
    chk("R5 pwrModeCmd", 16'(pwrModeCmd), 16'(mPm));
    chk("R9 testMode/unidirEnable", 16'({testMode, unidirEnable}), 16'({mTest, mUni}));
    chk("R8 loopback outputs", 16'({lbInternal, lbExternal, lbRemote}),
        16'({mLoop && mLbt == 0, mLoop && (mLbt == 1 || mLbt == 2), mLoop && mLbt == 3}));
  end

  task automatic drive(input logic [4:0] a, input logic [15:0] d, input bit we, input bit re,
                       input string tag);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = we; rdEn = re;
    #1;
    if (re) chk(tag, rdData, modelRead(a));
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    drive(a, d, 1, 0, "");
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    drive(a, 16'h0, 0, 1, tag);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checking = 1;
    // R1 reset values
    rd(0, "R1 basic reset value");
    chk("R1 basic literal", rdData, 16'h2100);
    rd(1, "R1 ext reset value");
    chk("R1 ext literal", rdData, 16'h0000);
    // R2 fixed bits and speed code
    wr(0, 16'h7BDF);  rd(0, "R2 fixed bits after all-ones write");
    wr(0, 16'h0000);  rd(0, "R2 cleared");
    chk("R2 literal", rdData, 16'h2100);
    // R3 conflicts
    wr(0, 16'h0800);  wr(0, 16'h0C00); rd(0, "R3 iso rejected while pd");
    wr(0, 16'h0000);  wr(0, 16'h0400); wr(0, 16'h0C00); rd(0, "R3 pd rejected while iso");
    wr(0, 16'h0000);  wr(0, 16'h0C00); rd(0, "R3 both requested rejected");
    // R5 power mode
    wr(1, 16'h3000);  wr(1, 16'h0000); rd(1, "R5 zero keeps");
    wr(1, 16'h9000);  wr(1, 16'hA000); wr(1, 16'h5000); rd(1, "R5 illegal rejected");
    wr(1, 16'hB000);  wr(1, 16'hC000); rd(1, "R5 standby accepted");
    // R4 normal request
    wr(0, 16'h0800);  wr(0, 16'h0000);
    wr(1, 16'h3000);  wr(0, 16'h0800); wr(0, 16'h0000);
    chk("R4 mode held", 16'(pwrModeCmd), 16'h3);
    // R6 command pulses
    wr(1, 16'h0E00);  rd(1, "R6 command bits read 0");
    wr(1, 16'h0400);  wr(1, 16'h0200);
    // R8 loopback kinds
    wr(1, 16'h0000);  wr(0, 16'h4000);
    wr(1, 16'h0080);  wr(1, 16'h0100); wr(1, 16'h0180); rd(1, "R8 type readback");
    wr(0, 16'h0000);
    // R9 storage and unmapped address
    wr(1, 16'h0070);  wr(0, 16'h0020); rd(0, "R9 unidirectional");
    wr(2, 16'hFFFF);  rd(2, "R9 unmapped read");
    rd(1, "R9 test mode");
    // read during write returns the old value
    drive(0, 16'h4000, 1, 1, "R9 read during write");
    // R7 reset together with a conflict
    wr(0, 16'h0800);  wr(1, 16'hC050);
    wr(0, 16'h8C00);  rd(0, "R7 basic defaults");
    rd(1, "R7 ext defaults");
    chk("R7 literal", rdData, 16'h0000);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (($urandom % 8) != 0) d[15] = 1'b0;
      drive(5'($urandom % 3), d, 1'($urandom % 4 != 0), 1'($urandom % 2), "R9 random readback");
    end
    drive(0, 16'h0, 0, 0, "");
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule